// File: doc/BRIEF.md
# Two-Stage Voice Activity Wake Detector

This block listens to one stream of signed PCM samples from a single microphone and decides when a person has started to speak. It is small enough to stay powered in an always-on domain while the rest of the chip sleeps. Samples are grouped into frames whose length is a power of two. A coarse first stage compares the summed sample magnitude of each frame with a fixed trigger level. A frame above that level starts the second stage. The second stage asks whether the following frames stand clearly above a slowly tracked noise floor. Quiet frames seen while listening move the noise floor towards their own energy. The step is an exponential average with a programmable shift.

Once enough consecutive frames pass the second stage, the block raises a wake request and holds it until the host acknowledges it. Every incoming sample also goes into a pre-roll ring. After the acknowledgement, the ring is streamed out over a valid/ready interface, oldest sample first, so the consumer also receives the speech onset that arrived before the wake decision. New samples keep arriving during the stream-out. They are appended when the ring has room. When the ring is full they are dropped and a sticky overflow flag is set.

Top module: `voice_wake_detect`

## Requirements
- R1: After reset, wake_req, out_valid and ovf_flag are 0, and noise_floor equals cfg_base_init.
- R2: Frame energy is the sum of the magnitudes of 2^FRAME_LOG2 consecutive accepted samples (in_valid high), read as two's complement. A frame triggers only when its energy is strictly greater than cfg_trig_thresh.
- R3: Only a frame that ends while listening and does not trigger updates noise_floor. If E ≥ F the new floor is F + ((E − F) >> cfg_avg_shift), otherwise F − ((F − E) >> cfg_avg_shift), with truncating shifts. No other frame changes noise_floor.
- R4: After a trigger frame, each following frame passes when 8·E > F·cfg_ratio (cfg_ratio in eighths). The trigger frame itself is not counted. Once cfg_confirm_frames consecutive frames have passed, wake_req rises one cycle after the frame closes. A failing frame sends the block back to listening, and a new trigger is needed.
- R5: wake_req stays high until a cycle with wake_ack high. wake_ack has no effect while wake_req is low.
- R6: Outside stream-out, the ring keeps the most recent BUF_DEPTH samples and discards older ones.
- R7: After the acknowledgement the ring contents appear on out_sample, oldest first, one per cycle with out_valid and out_ready both high. out_valid is never high together with wake_req. Once the ring is empty, out_valid falls and the block returns to listening.
- R8: During stream-out, a new sample is stored when the ring is not full, or when a read happens in the same cycle. Otherwise it is dropped without disturbing stored data and ovf_flag is set. ovf_flag stays set until the next acknowledgement, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new PCM sample is present |
| in_sample | input | SAMPLE_W | Signed PCM sample |
| cfg_trig_thresh | input | EW | First-stage frame energy trigger level |
| cfg_ratio | input | RATIO_W | Confirmation ratio over noise floor, in eighths |
| cfg_confirm_frames | input | CONF_W | Consecutive passing frames needed to wake |
| cfg_avg_shift | input | SHIFT_W | Noise floor averaging shift |
| cfg_base_init | input | EW | Noise floor value loaded at reset |
| wake_req | output | 1 | Wake request to the host |
| wake_ack | input | 1 | Host acknowledge, starts stream-out |
| out_valid | output | 1 | Stream-out sample available |
| out_ready | input | 1 | Consumer accepts the sample |
| out_sample | output | SAMPLE_W | Stream-out sample |
| ovf_flag | output | 1 | Sample dropped during stream-out |
| noise_floor | output | EW | Current tracked noise floor |

## Verification
During stream-out, the write of a freshly captured sample and the read of the oldest stored one can land on the same clock edge, and this matters most when the ring is full. The bench enters stream-out with a full ring, raises in_valid and out_ready in one cycle, and expects no overflow, with the new sample at the tail of the remaining stream. It then repeats the write with out_ready low and expects the overflow flag, an unchanged head sample, and the dropped value missing from the drained sequence.

// File: rtl/vwd_pkg.sv
package vwd_pkg;

    typedef enum logic [1:0] {
        ST_LISTEN  = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_WAKE    = 2'd2,
        ST_REPLAY  = 2'd3
    } vwd_state_e;

    // fractional bits of the confirmation ratio (ratio is in eighths)
    localparam int RATIO_FRAC = 3;

    typedef struct packed {
        logic wr;
        logic rd;
        logic drop;
        logic evict;
    } ring_op_t;

endpackage

// File: rtl/vwd_energy.sv
module vwd_energy #(
    parameter int SAMPLE_W   = 16,
    parameter int FRAME_LOG2 = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           in_valid,
    input  logic [SAMPLE_W-1:0]            in_sample,
    output logic                           frame_done,
    output logic [SAMPLE_W+FRAME_LOG2-1:0] frame_energy
);
    localparam int EW = SAMPLE_W + FRAME_LOG2;

    logic [FRAME_LOG2-1:0] idx;
    logic [EW-1:0]         acc;
    logic [SAMPLE_W-1:0]   mag;
    logic [EW-1:0]         sum_next;

    always_comb begin
        if (in_sample[SAMPLE_W-1])
            mag = (~in_sample) + {{(SAMPLE_W-1){1'b0}}, 1'b1};
        else
            mag = in_sample;
        sum_next = acc + {{FRAME_LOG2{1'b0}}, mag};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx          <= '0;
            acc          <= '0;
            frame_done   <= 1'b0;
            frame_energy <= '0;
        end else begin
            frame_done <= 1'b0;
            if (in_valid) begin
                idx <= idx + 1'b1;
                if (&idx) begin
                    frame_energy <= sum_next;
                    frame_done   <= 1'b1;
                    acc          <= '0;
                end else begin
                    acc <= sum_next;
                end
            end
        end
    end
endmodule

// File: rtl/vwd_ring.sv
module vwd_ring
    import vwd_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                replay,
    input  logic                wr_en,
    input  logic [SAMPLE_W-1:0] wr_data,
    input  logic                rd_en,
    input  logic                clr_ovf,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic                empty,
    output logic                ovf
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [SAMPLE_W-1:0] mem [DEPTH];
    logic [PW-1:0]       wp;
    logic [PW-1:0]       rp;
    logic [CW-1:0]       cnt;
    logic                full;
    ring_op_t            op;

    always_comb begin
        full     = (cnt == CW'(DEPTH));
        empty    = (cnt == '0);
        op.rd    = replay && rd_en && !empty;
        op.wr    = wr_en && (!replay || !full || op.rd);
        op.drop  = wr_en && replay && full && !op.rd;
        op.evict = wr_en && !replay && full;
        rd_data  = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (op.wr)
            mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (op.wr)
                wp <= wp + 1'b1;
            if (op.rd || op.evict)
                rp <= rp + 1'b1;
            if (op.wr && !op.evict && !op.rd)
                cnt <= cnt + 1'b1;
            else if (op.rd && !op.wr)
                cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ovf <= 1'b0;
        else if (clr_ovf)
            ovf <= 1'b0;
        else if (op.drop)
            ovf <= 1'b1;
    end
endmodule

// File: rtl/vwd_ctrl.sv
module vwd_ctrl
    import vwd_pkg::*;
#(
    parameter int EW      = 20,
    parameter int RATIO_W = 4,
    parameter int CONF_W  = 4,
    parameter int SHIFT_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_done,
    input  logic [EW-1:0]      frame_energy,
    input  logic [EW-1:0]      cfg_trig_thresh,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic [CONF_W-1:0]  cfg_confirm_frames,
    input  logic [SHIFT_W-1:0] cfg_avg_shift,
    input  logic [EW-1:0]      cfg_base_init,
    input  logic               wake_ack,
    input  logic               ring_empty,
    output vwd_state_e         state,
    output logic [EW-1:0]      noise_floor,
    output logic               replay_start
);
    localparam int CMP_W = EW + RATIO_W + 1;
    localparam int LPAD  = CMP_W - EW - RATIO_FRAC;

    logic [CMP_W-1:0]  lhs;
    logic [CMP_W-1:0]  rhs;
    logic              trig;
    logic              pass;
    logic [EW-1:0]     diff;
    logic [EW-1:0]     step;
    logic [EW-1:0]     floor_next;
    logic [CONF_W-1:0] hits;
    logic [CONF_W:0]   hits_inc;

    always_comb begin
        lhs  = {{LPAD{1'b0}}, frame_energy, {RATIO_FRAC{1'b0}}};
        rhs  = {{(RATIO_W+1){1'b0}}, noise_floor} * {{(EW+1){1'b0}}, cfg_ratio};
        pass = lhs > rhs;
        trig = frame_energy > cfg_trig_thresh;
        if (frame_energy >= noise_floor) begin
            diff       = frame_energy - noise_floor;
            step       = diff >> cfg_avg_shift;
            floor_next = noise_floor + step;
        end else begin
            diff       = noise_floor - frame_energy;
            step       = diff >> cfg_avg_shift;
            floor_next = noise_floor - step;
        end
        hits_inc     = {1'b0, hits} + 1'b1;
        replay_start = (state == ST_WAKE) && wake_ack;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_LISTEN;
            noise_floor <= cfg_base_init;
            hits        <= '0;
        end else begin
            unique case (state)
                ST_LISTEN: begin
                    if (frame_done) begin
                        if (trig) begin
                            state <= ST_CONFIRM;
                            hits  <= '0;
                        end else begin
                            noise_floor <= floor_next;
                        end
                    end
                end
                ST_CONFIRM: begin
                    if (frame_done) begin
                        if (!pass)
                            state <= ST_LISTEN;
                        else if (hits_inc >= {1'b0, cfg_confirm_frames})
                            state <= ST_WAKE;
                        else
                            hits <= hits_inc[CONF_W-1:0];
                    end
                end
                ST_WAKE: begin
                    if (wake_ack)
                        state <= ST_REPLAY;
                end
                ST_REPLAY: begin
                    if (ring_empty)
                        state <= ST_LISTEN;
                end
                default: state <= ST_LISTEN;
            endcase
        end
    end
endmodule

// File: rtl/voice_wake_detect.sv
module voice_wake_detect
    import vwd_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int FRAME_LOG2 = 4,
    parameter int BUF_DEPTH  = 32,
    parameter int RATIO_W    = 4,
    parameter int CONF_W     = 4,
    parameter int SHIFT_W    = 4,
    localparam int EW        = SAMPLE_W + FRAME_LOG2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [EW-1:0]       cfg_trig_thresh,
    input  logic [RATIO_W-1:0]  cfg_ratio,
    input  logic [CONF_W-1:0]   cfg_confirm_frames,
    input  logic [SHIFT_W-1:0]  cfg_avg_shift,
    input  logic [EW-1:0]       cfg_base_init,
    output logic                wake_req,
    input  logic                wake_ack,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic                ovf_flag,
    output logic [EW-1:0]       noise_floor
);
    logic          frame_done;
    logic [EW-1:0] frame_energy;
    logic          ring_empty;
    logic          replay_start;
    vwd_state_e    state;

    vwd_energy #(
        .SAMPLE_W  (SAMPLE_W),
        .FRAME_LOG2(FRAME_LOG2)
    ) u_energy (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_sample   (in_sample),
        .frame_done  (frame_done),
        .frame_energy(frame_energy)
    );

    vwd_ctrl #(
        .EW     (EW),
        .RATIO_W(RATIO_W),
        .CONF_W (CONF_W),
        .SHIFT_W(SHIFT_W)
    ) u_ctrl (
        .clk               (clk),
        .rst               (rst),
        .frame_done        (frame_done),
        .frame_energy      (frame_energy),
        .cfg_trig_thresh   (cfg_trig_thresh),
        .cfg_ratio         (cfg_ratio),
        .cfg_confirm_frames(cfg_confirm_frames),
        .cfg_avg_shift     (cfg_avg_shift),
        .cfg_base_init     (cfg_base_init),
        .wake_ack          (wake_ack),
        .ring_empty        (ring_empty),
        .state             (state),
        .noise_floor       (noise_floor),
        .replay_start      (replay_start)
    );

    vwd_ring #(
        .SAMPLE_W(SAMPLE_W),
        .DEPTH   (BUF_DEPTH)
    ) u_ring (
        .clk    (clk),
        .rst    (rst),
        .replay (state == ST_REPLAY),
        .wr_en  (in_valid),
        .wr_data(in_sample),
        .rd_en  (out_ready),
        .clr_ovf(replay_start),
        .rd_data(out_sample),
        .empty  (ring_empty),
        .ovf    (ovf_flag)
    );

    always_comb begin
        wake_req  = (state == ST_WAKE);
        out_valid = (state == ST_REPLAY) && !ring_empty;
    end
endmodule

// File: rtl/vwd_checker.sv
module vwd_checker #(
    parameter int SAMPLE_W = 16,
    parameter int EW       = 20
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                wake_req,
    input logic                wake_ack,
    input logic                out_valid,
    input logic                out_ready,
    input logic [SAMPLE_W-1:0] out_sample,
    input logic                ovf_flag,
    input logic [EW-1:0]       noise_floor
);
    p_wake_hold_r5: assert property (@(posedge clk) disable iff (rst)
        wake_req && !wake_ack |=> wake_req);

    p_no_stream_in_wake_r7: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> !out_valid);

    p_head_hold_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_sample));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        ovf_flag && !wake_ack |=> ovf_flag);

    p_ovf_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> $past(in_valid) && !$past(out_ready));

    p_floor_at_frame_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(noise_floor) |-> $past(in_valid, 2));
endmodule

bind voice_wake_detect vwd_checker #(
    .SAMPLE_W(SAMPLE_W),
    .EW      (EW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .wake_req   (wake_req),
    .wake_ack   (wake_ack),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_sample (out_sample),
    .ovf_flag   (ovf_flag),
    .noise_floor(noise_floor)
);

// File: tb/voice_wake_detect_tb.sv
module voice_wake_detect_tb;
    localparam int SW    = 16;
    localparam int FL2   = 4;
    localparam int FLEN  = 1 << FL2;
    localparam int DEPTH = 32;
    localparam int EW    = SW + FL2;
    localparam int SHIFT = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_sample = '0;
    logic          wake_ack = 1'b0;
    logic          out_ready = 1'b0;
    logic          wake_req, out_valid, ovf_flag;
    logic [SW-1:0] out_sample;
    logic [EW-1:0] noise_floor;

    int checks = 0;
    int errors = 0;
    int base_m = 1600;
    int q[$];
    bit replay_m = 0;
    int seq_base = 2000;

    always #5 clk = ~clk;

    voice_wake_detect #(.SAMPLE_W(SW), .FRAME_LOG2(FL2), .BUF_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .cfg_trig_thresh(20'd16000), .cfg_ratio(4'd12), .cfg_confirm_frames(4'd3),
        .cfg_avg_shift(4'(SHIFT)), .cfg_base_init(20'd1600),
        .wake_req(wake_req), .wake_ack(wake_ack), .out_valid(out_valid),
        .out_ready(out_ready), .out_sample(out_sample), .ovf_flag(ovf_flag),
        .noise_floor(noise_floor)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int upd(input int b, input int e);
        if (e >= b) return b + ((e - b) >>> SHIFT);
        return b - ((b - e) >>> SHIFT);
    endfunction

    // one sample, one cycle of in_valid; model of ring outside stream-out
    task automatic drive(input int v);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = SW'(v);
        @(negedge clk);
        in_valid = 1'b0;
        if (!replay_m) begin
            q.push_back(v);
            if (q.size() > DEPTH) void'(q.pop_front());
        end
    endtask

    task automatic frame_const(input int v);
        for (int i = 0; i < FLEN; i++) drive(v);
        @(negedge clk);
    endtask

    task automatic frame_loud();
        for (int i = 0; i < FLEN; i++) drive((i % 2) ? -(seq_base + i) : (seq_base + i));
        seq_base += 100;
        @(negedge clk);
    endtask

    task automatic drain(input int exp_n, input string req);
        int n = 0;
        out_ready = 1'b1;
        while (out_valid && n < 2 * DEPTH) begin
            chk(req, $signed(out_sample), q[0]);
            void'(q.pop_front());
            n++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(req, n, exp_n);
        @(negedge clk);
        chk(req, out_valid, 0);
        replay_m = 0;
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        wake_ack = 1'b1;
        @(negedge clk);
        wake_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 wake_req", wake_req, 0);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 ovf_flag", ovf_flag, 0);
        chk("R1 noise_floor", noise_floor, 1600);
    endtask

    task automatic t_baseline();
        frame_const(-50);                        // energy 800, negative samples
        base_m = upd(base_m, 800);
        chk("R3 floor after quiet negative frame (R2 magnitude)", noise_floor, base_m);
        frame_const(1000);                       // energy equals threshold: no trigger
        base_m = upd(base_m, 16000);
        chk("R2 threshold is strict, floor moved up", noise_floor, base_m);
        frame_const(0);
        base_m = upd(base_m, 0);
        chk("R3 floor after silent frame", noise_floor, base_m);
        chk("R2 no wake from quiet frames", wake_req, 0);
    endtask

    task automatic t_confirm();
        frame_loud();                            // trigger
        chk("R3 trigger frame leaves floor", noise_floor, base_m);
        frame_const(0);                          // fails confirmation
        chk("R3 failing confirm frame leaves floor", noise_floor, base_m);
        chk("R4 failed confirm gives no wake", wake_req, 0);
        frame_loud();                            // new trigger
        frame_loud();
        frame_loud();
        chk("R4 two passing frames are not enough", wake_req, 0);
        frame_loud();
        chk("R4 wake after three passing frames", wake_req, 1);
        chk("R3 floor unchanged through confirmation", noise_floor, base_m);
    endtask

    task automatic t_wake_hold();
        repeat (20) @(negedge clk);
        chk("R5 wake_req held without ack", wake_req, 1);
        chk("R7 no stream while waking", out_valid, 0);
    endtask

    task automatic t_replay();
        chk("R6 ring holds newest DEPTH samples", q.size(), DEPTH);
        replay_m = 1;
        out_ready = 1'b1;
        ack_pulse();
        chk("R5 wake_req falls after ack", wake_req, 0);
        drain(DEPTH, "R7 replay order");
        chk("R7 back to listening, no wake", wake_req, 0);
    endtask

    task automatic t_ack_ignored();
        frame_const(0);
        base_m = upd(base_m, 0);
        ack_pulse();
        @(negedge clk);
        chk("R5 ack while listening: no wake", wake_req, 0);
        chk("R5 ack while listening: no stream", out_valid, 0);
        chk("R3 floor after listening frame", noise_floor, base_m);
    endtask

    task automatic t_overflow();
        int head;
        repeat (4) frame_loud();
        chk("R4 second wake", wake_req, 1);
        replay_m = 1;
        ack_pulse();
        chk("R8 ovf clear at start of stream", ovf_flag, 0);
        chk("R7 stream valid after ack", out_valid, 1);
        // write and read on the same edge with a full ring
        @(negedge clk);
        chk("R7 head before concurrent read", $signed(out_sample), q[0]);
        void'(q.pop_front());
        q.push_back(7);
        in_valid = 1'b1; in_sample = SW'(7); out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b0;
        chk("R8 concurrent read and write: no overflow", ovf_flag, 0);
        head = q[0];
        drive(9);                                // full, no read: dropped
        chk("R8 overflow flagged on drop", ovf_flag, 1);
        chk("R8 head untouched by dropped sample", $signed(out_sample), head);
        drain(DEPTH, "R8 stream after concurrent write and drop");
        chk("R8 overflow flag sticky", ovf_flag, 1);
        // realign frame count: 2 samples already in this frame
        for (int i = 0; i < FLEN - 2; i++) drive(0);
        @(negedge clk);
        base_m = upd(base_m, 16);
        chk("R3 floor after mixed frame", noise_floor, base_m);
        repeat (4) frame_loud();
        chk("R4 third wake", wake_req, 1);
        chk("R8 flag still set before ack", ovf_flag, 1);
        replay_m = 1;
        ack_pulse();
        chk("R8 ack clears overflow", ovf_flag, 0);
        drain(DEPTH, "R7 third stream");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_baseline();
        t_confirm();
        t_wake_hold();
        t_replay();
        t_ack_ignored();
        t_overflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule